// File: doc/BRIEF.md
# Destination Address Receive Filter

This block decides whether a received Ethernet frame is kept, using only its 48-bit destination address. It holds a table of ten station addresses, six bytes each. Software loads the table one byte at a time through a paged byte interface. Each page shows eight data registers at offsets 8 to 15. The table starts at page 0x50 and its bytes run on without gaps, so one address can begin on one page and end on the next.

A frame's destination address enters as six byte strobes, least significant byte first; the first byte is flagged with a start marker. One clock after the sixth byte, the block gives its verdict and a small status word. The status word says whether the address was physical or multicast, whether it was broadcast, and whether it hit a stored entry. Four mode bits control the verdict: extra-entry enable, accept all multicast, promiscuous, and broadcast reject. A separate multicast hash block supplies a hit input and an enable input.

Top module: `da_rx_filter`

## Requirements
- R1: After reset, `flt_vld`, `flt_accept` and `flt_status` are all zero.
- R2: A write with page P in 0x50..0x57 and register offset O in 8..15 stores the byte at table index (P-0x50)*8+(O-8). Entry e byte b (b=0 is the least significant byte) sits at index 6e+b, so an entry may straddle two pages.
- R3: Writes are ignored when the page lies outside 0x50..0x57, when the offset is below 8, or when the index is 60 or more.
- R4: Entry 0 is always compared. Entries 1 to 9 are compared only when `filt_cfg[0]` is 1.
- R5: `flt_vld` pulses for exactly one cycle, on the clock after the sixth accepted byte. A byte with `da_sof` set restarts the byte count at byte 0.
- R6: `flt_status` bit 0 is 1 for a physical address (bit 0 of byte 0 is 0) and 0 for multicast. Bit 1 is 1 for broadcast (all 48 bits set). Bit 3 is 1 when a compared entry equals the address. Bit 2 is always 0.
- R7: A broadcast frame is accepted exactly when `filt_cfg[3]` is 0.
- R8: A non-broadcast frame that matches a compared entry is accepted.
- R9: An unmatched multicast frame that is not broadcast is accepted exactly when `filt_cfg[1]` is 1, or when both `hash_en` and `hash_hit` are 1.
- R10: An unmatched physical frame is accepted exactly when `filt_cfg[2]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table byte write strobe |
| tbl_page | input | 8 | Register page of the write |
| tbl_reg | input | 4 | Register offset within the page |
| tbl_wdata | input | 8 | Byte to store |
| filt_cfg | input | 4 | Mode bits: 0 extra entries, 1 all multicast, 2 promiscuous, 3 broadcast reject |
| hash_en | input | 1 | Multicast hash filtering enabled |
| hash_hit | input | 1 | Hash block reports a hit for this frame |
| da_vld | input | 1 | Destination byte strobe |
| da_sof | input | 1 | Marks the first destination byte |
| da_byte | input | 8 | Destination byte, least significant first |
| flt_vld | output | 1 | Verdict valid pulse |
| flt_accept | output | 1 | Frame accepted |
| flt_status | output | 4 | Physical, broadcast, reserved zero, matched |

## Verification
The assertions assume that `filt_cfg`, `hash_en` and `hash_hit` are stable on the clock edge that takes the sixth byte. They also assume each frame's bytes start with a `da_sof` byte, so a verdict is always based on a whole address. The bench sets the mode inputs before the first byte and holds them until the verdict has been sampled. Every address sequence begins with a start-marked byte; the single deliberately broken sequence is followed by a fresh start marker. No table write happens while an address is arriving.

// File: rtl/da_rx_filter.sv
`timescale 1ns/1ps
module da_rx_filter #(
  parameter int N_ENT     = 10,
  parameter int AW        = 48,
  parameter int PAGE_BASE = 8'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tbl_we,
  input  logic [7:0] tbl_page,
  input  logic [3:0] tbl_reg,
  input  logic [7:0] tbl_wdata,
  input  logic [3:0] filt_cfg,
  input  logic       hash_en,
  input  logic       hash_hit,
  input  logic       da_vld,
  input  logic       da_sof,
  input  logic [7:0] da_byte,
  output logic       flt_vld,
  output logic       flt_accept,
  output logic [3:0] flt_status
);
  localparam int NB    = AW / 8;
  localparam int TB    = N_ENT * NB;
  localparam int NPAGE = (TB + 7) / 8;
  localparam int CW    = $clog2(NB);

  logic [7:0] tab_q [TB];
  logic [7:0] pg_off;
  logic [10:0] widx;
  logic wr_ok;

  assign pg_off = tbl_page - 8'(PAGE_BASE);
  assign widx   = {pg_off, tbl_reg[2:0]};
  assign wr_ok  = tbl_we && tbl_reg[3] && (int'(pg_off) < NPAGE) && (int'(widx) < TB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TB; i++) tab_q[i] <= '0;
    end else if (wr_ok) begin
      tab_q[widx] <= tbl_wdata;
    end
  end

  logic [7:0] da_q [NB-1];
  logic [CW-1:0] cnt_q, pos;
  logic last;
  logic [AW-1:0] da_full;

  assign pos  = da_sof ? '0 : cnt_q;
  assign last = da_vld && (pos == CW'(NB-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < NB-1; i++) da_q[i] <= '0;
    end else if (da_vld) begin
      if (last) cnt_q <= '0;
      else begin
        da_q[pos] <= da_byte;
        cnt_q     <= pos + 1'b1;
      end
    end
  end

  always_comb begin
    da_full = '0;
    for (int b = 0; b < NB-1; b++) da_full[8*b +: 8] = da_q[b];
    da_full[AW-8 +: 8] = da_byte;
  end

  logic [N_ENT-1:0] hit;
  genvar e, b;
  generate
    for (e = 0; e < N_ENT; e++) begin : g_ent
      logic [AW-1:0] ent;
      for (b = 0; b < NB; b++) begin : g_byte
        assign ent[8*b +: 8] = tab_q[e*NB + b];
      end
      if (e == 0) begin : g_always
        assign hit[e] = (ent == da_full);
      end else begin : g_opt
        assign hit[e] = filt_cfg[0] && (ent == da_full);
      end
    end
  endgenerate

  logic mc, bc, mt, acc;
  assign mc = da_full[0];
  assign bc = &da_full;
  assign mt = |hit;

  always_comb begin
    if (bc)      acc = !filt_cfg[3];
    else if (mt) acc = 1'b1;
    else if (mc) acc = filt_cfg[1] || (hash_en && hash_hit);
    else         acc = filt_cfg[2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flt_vld    <= 1'b0;
      flt_accept <= 1'b0;
      flt_status <= '0;
    end else begin
      flt_vld <= last;
      if (last) begin
        flt_accept <= acc;
        flt_status <= {mt, 1'b0, bc, !mc};
      end
    end
  end

  AST_VLD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n) flt_vld |-> $past(da_vld)); // R5
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) flt_vld |=> !flt_vld); // R5
  AST_BCAST_NOT_PHYS: assert property (@(posedge clk) disable iff (!rst_n) (flt_vld && flt_status[1]) |-> !flt_status[0]); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !flt_status[2]); // R6
  AST_BCAST_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (last && bc) |=> (flt_accept == !$past(filt_cfg[3]))); // R7
  AST_MATCH_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (flt_vld && flt_status[3] && !flt_status[1]) |-> flt_accept); // R8
  AST_PROMISC: assert property (@(posedge clk) disable iff (!rst_n) (last && !mc && !mt && filt_cfg[2]) |=> flt_accept); // R10
endmodule

// File: tb/tb_da_rx_filter.sv
`timescale 1ns/1ps
module tb_da_rx_filter;
  logic clk = 0, rst_n = 0;
  logic tbl_we = 0; logic [7:0] tbl_page = 0; logic [3:0] tbl_reg = 0; logic [7:0] tbl_wdata = 0;
  logic [3:0] filt_cfg = 0; logic hash_en = 0, hash_hit = 0;
  logic da_vld = 0, da_sof = 0; logic [7:0] da_byte = 0;
  logic flt_vld, flt_accept; logic [3:0] flt_status;
  int checks = 0, fails = 0;
  logic [47:0] tab [10];

  always #5 clk = ~clk;

  da_rx_filter dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] pg, input logic [3:0] rg, input logic [7:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_page = pg; tbl_reg = rg; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic wr_entry(input int e, input logic [47:0] a);
    for (int b = 0; b < 6; b++) begin
      int idx = 6*e + b;
      wr_byte(8'h50 + 8'(idx/8), 4'(8 + idx%8), a[8*b +: 8]);
    end
    tab[e] = a;
  endtask

  task automatic send(input logic [47:0] a, input logic [3:0] cfg, input logic he, input logic hh);
    @(negedge clk);
    filt_cfg = cfg; hash_en = he; hash_hit = hh;
    for (int b = 0; b < 6; b++) begin
      if (b > 0) @(negedge clk);
      da_vld = 1; da_sof = (b == 0); da_byte = a[8*b +: 8];
    end
    @(negedge clk);
    da_vld = 0; da_sof = 0;
  endtask

  task automatic frame(input string req, input logic [47:0] a, input logic [3:0] cfg,
                       input logic he, input logic hh);
    logic mc, bc, mt, acc;
    mc = a[0]; bc = &a;
    mt = (a == tab[0]);
    for (int e = 1; e < 10; e++) if (cfg[0] && a == tab[e]) mt = 1;
    if (bc) acc = !cfg[3];
    else if (mt) acc = 1;
    else if (mc) acc = cfg[1] | (he & hh);
    else acc = cfg[2];
    send(a, cfg, he, hh);
    chk({req, " vld"}, 32'(flt_vld), 1);
    chk({req, " accept"}, 32'(flt_accept), 32'(acc));
    chk({req, " status"}, 32'(flt_status), 32'({mt, 1'b0, bc, !mc}));
    @(negedge clk);
    chk({req, " R5 pulse end"}, 32'(flt_vld), 0);
  endtask

  task automatic t_reset();
    chk("R1 vld", 32'(flt_vld), 0);
    chk("R1 accept", 32'(flt_accept), 0);
    chk("R1 status", 32'(flt_status), 0);
  endtask

  task automatic t_program();
    wr_entry(0, 48'h665544332210);
    wr_entry(1, 48'hA1B2C3D4E520); // R2 straddles pages 0x50/0x51
    wr_entry(2, 48'h0102030405C1);
    wr_entry(9, 48'h123456789A90);
    frame("R2 entry0", tab[0], 4'h0, 0, 0);
    frame("R2 straddle", tab[1], 4'h1, 0, 0);
    frame("R2 last entry", tab[9], 4'h1, 0, 0);
  endtask

  task automatic t_enable();
    frame("R4 entry1 off", tab[1], 4'h0, 0, 0);
    frame("R4 entry9 off", tab[9], 4'h0, 0, 0);
    frame("R4 entry0 always", tab[0], 4'h0, 0, 0);
    frame("R8 mcast entry", tab[2], 4'h1, 0, 0);
  endtask

  task automatic t_mcast();
    frame("R9 mc none", 48'h00000000AB03, 4'h0, 0, 0);
    frame("R9 mc all", 48'h00000000AB03, 4'h2, 0, 0);
    frame("R9 mc hash", 48'h00000000AB03, 4'h0, 1, 1);
    frame("R9 mc hash off", 48'h00000000AB03, 4'h0, 0, 1);
    frame("R9 mc en no hit", 48'h00000000AB03, 4'h0, 1, 0);
  endtask

  task automatic t_bcast();
    frame("R7 bc keep", 48'hFFFFFFFFFFFF, 4'h0, 0, 0);
    frame("R7 bc reject", 48'hFFFFFFFFFFFF, 4'h8, 0, 0);
    frame("R7 bc reject allmc", 48'hFFFFFFFFFFFF, 4'hA, 1, 1);
  endtask

  task automatic t_promisc();
    frame("R10 phys drop", 48'h0000CAFE0042, 4'h0, 0, 0);
    frame("R10 phys promisc", 48'h0000CAFE0042, 4'h4, 0, 0);
    frame("R6 phys allmc only", 48'h0000CAFE0042, 4'h2, 1, 1);
  endtask

  task automatic t_ignored();
    wr_byte(8'h50, 4'h0, 8'hEE); // R3 offset below 8
    wr_byte(8'h48, 4'h8, 8'hEE); // R3 page below window
    wr_byte(8'h58, 4'h9, 8'hEE); // R3 page above window
    wr_byte(8'h57, 4'hC, 8'hEE); // R3 index 60
    frame("R3 entry0 intact", tab[0], 4'h0, 0, 0);
    frame("R3 entry1 intact", tab[1], 4'h1, 0, 0);
    frame("R3 entry9 intact", tab[9], 4'h1, 0, 0);
  endtask

  task automatic t_resync();
    for (int b = 0; b < 3; b++) begin
      @(negedge clk);
      da_vld = 1; da_sof = (b == 0); da_byte = 8'h77;
    end
    @(negedge clk);
    da_vld = 0; da_sof = 0;
    @(negedge clk);
    chk("R5 partial no vld", 32'(flt_vld), 0);
    frame("R5 restart", tab[0], 4'h0, 0, 0);
  endtask

  initial begin
    for (int e = 0; e < 10; e++) tab[e] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_program();
    t_enable();
    t_mcast();
    t_bcast();
    t_promisc();
    t_ignored();
    t_resync();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule